// File: doc/BRIEF.md
# Outbound Address Translation Window Unit

This block sits on the outbound side of a bus bridge and turns local-bus addresses into external-bus addresses. It holds a small bank of programmable windows. Each window has three registers: a local base, a translated base and an attribute word that carries an enable flag and a log2-coded size. A request is looked up against all enabled windows in parallel. The first matching window, where first means the lowest index, supplies the translated address. That address is the translated base plus the request's offset from the local base.

Two 32-bit words are reserved for configuration access, one for the address and one for the data. A request to either word is never forwarded, even when it lies inside an enabled window. A request that matches no window is not forwarded either. The result is registered and appears one clock after the request. Software programs the windows through a plain write port and reads them back combinationally through the same register select.

Top module: `xlat_outbound_unit`

## Requirements
- R1: After synchronous reset every window is disabled and every register reads zero. Outputs `xl_valid`, `xl_fwd`, `xl_addr` and `xl_win` are zero.
- R2: `cfg_sel` is {window index, field}. Field 0 is the local base and field 1 is the translated base. Each base keeps `cfg_wdata[19:0]` as address bits 31:12 and reads back zero-extended, so windows start on 4 KB boundaries.
- R3: Field 2 is the attribute word. Bit 31 is the enable and bits 5:0 are the size code. A window spans 2^(code+1) bytes. All other attribute bits read back as zero.
- R4: A request at offset N from an enabled window's local base gives `xl_fwd`=1. It also gives `xl_addr` = translated base + N (modulo 2^32) and `xl_win` = that window's index, one clock after the request.
- R5: The last byte of a window (base + size − 1) is inside the window. The byte at base + size is outside it.
- R6: A size code below 0x0B gives a 4 KB window. A code of 0x1F or above gives a 4 GB window that contains every address.
- R7: A request to any byte of the words at 0xE7FFFFF0 and 0xE7FFFFF4 gives `xl_fwd`=0 and `xl_addr`=0. Neighbouring addresses in the same window are forwarded.
- R8: When several enabled windows contain the request, the lowest-numbered window translates it.
- R9: A disabled window never matches. When no window matches, `xl_fwd`=0, `xl_addr`=0 and `xl_win`=0.
- R10: `xl_valid` is `req_valid` delayed by one clock. A cycle without a request gives `xl_fwd`=0.
- R11: Field code 3 is not a register. Writes to it change nothing and reads of it return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_sel | input | 4 | Register select {window index[1:0], field[1:0]} |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_sel` |
| req_valid | input | 1 | Local request present |
| req_addr | input | 32 | Local request address |
| xl_valid | output | 1 | Result valid, one clock after request |
| xl_fwd | output | 1 | Request is forwarded to the external bus |
| xl_addr | output | 32 | Translated external address, zero when not forwarded |
| xl_win | output | 2 | Index of the window that translated the request |

## Verification
The hardest case to reach is a request that several enabled windows contain at once. In that case the priority ordering, the carve-out and a whole-space window all act on the same address. The stimulus builds this step by step. A 128 MB window and a 4 KB window are laid over the same local range, then a 4 GB window is added on top. Windows are then disabled and re-enabled one at a time, so the same address moves from one window to another, and finally to no window. Around every window, the addresses at each edge (one byte below, first, last and one past) are swept and compared with an arithmetic model of the window set.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    localparam int unsigned ADDR_W   = 32;
    localparam int unsigned PAGE_W   = 12;
    localparam int unsigned PFN_W    = ADDR_W - PAGE_W;
    localparam int unsigned CODE_W   = 6;
    localparam int unsigned EN_BIT   = 31;
    localparam int unsigned CODE_MIN = PAGE_W - 1;
    localparam int unsigned CODE_MAX = ADDR_W - 1;

    typedef enum logic [1:0] {
        FLD_LOCAL = 2'd0,
        FLD_XLAT  = 2'd1,
        FLD_ATTR  = 2'd2,
        FLD_NONE  = 2'd3
    } fld_e;

    typedef struct packed {
        logic              en;
        logic [CODE_W-1:0] code;
        logic [PFN_W-1:0]  lbase;
        logic [PFN_W-1:0]  tbase;
    } win_cfg_t;

    typedef struct packed {
        logic              hit;
        logic [ADDR_W-1:0] xaddr;
    } win_res_t;

    // Byte span of a window; codes are clamped to the 4 KB .. 4 GB range.
    function automatic logic [ADDR_W:0] win_span(input logic [CODE_W-1:0] code);
        int unsigned eff;
        eff = int'(code);
        if (eff < CODE_MIN) eff = CODE_MIN;
        if (eff > CODE_MAX) eff = CODE_MAX;
        return (ADDR_W+1)'(1) << (eff + 1);
    endfunction

    function automatic logic [ADDR_W-1:0] pfn_to_addr(input logic [PFN_W-1:0] pfn);
        return {pfn, {PAGE_W{1'b0}}};
    endfunction

endpackage

// File: rtl/xlat_regs.sv
module xlat_regs
    import xlat_pkg::*;
#(
    parameter int unsigned NUM_WIN = 4,
    localparam int unsigned IDX_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
    localparam int unsigned SEL_W  = IDX_W + 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [SEL_W-1:0]            sel,
    input  logic [ADDR_W-1:0]           wdata,
    output logic [ADDR_W-1:0]           rdata,
    output win_cfg_t [NUM_WIN-1:0]      cfg
);

    logic [IDX_W-1:0] idx;
    fld_e             fld;
    logic             idx_ok;
    logic [NUM_WIN-1:0] en_vec;
    logic [PFN_W-2:0] unused_wbits;

    assign idx          = sel[SEL_W-1:2];
    assign fld          = fld_e'(sel[1:0]);
    assign idx_ok       = (int'(idx) < NUM_WIN);
    assign unused_wbits = wdata[EN_BIT-1:PFN_W];

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        always_ff @(posedge clk) begin
            if (rst) begin
                cfg[w] <= '0;
            end else if (wr_en && idx_ok && (int'(idx) == w)) begin
                case (fld)
                    FLD_LOCAL: cfg[w].lbase <= wdata[PFN_W-1:0];
                    FLD_XLAT:  cfg[w].tbase <= wdata[PFN_W-1:0];
                    FLD_ATTR: begin
                        cfg[w].en   <= wdata[EN_BIT];
                        cfg[w].code <= wdata[CODE_W-1:0];
                    end
                    default: ;
                endcase
            end
        end
        assign en_vec[w] = cfg[w].en;
    end

    always_comb begin
        rdata = '0;
        if (idx_ok) begin
            case (fld)
                FLD_LOCAL: rdata = {{PAGE_W{1'b0}}, cfg[idx].lbase};
                FLD_XLAT:  rdata = {{PAGE_W{1'b0}}, cfg[idx].tbase};
                FLD_ATTR: begin
                    rdata[EN_BIT]       = cfg[idx].en;
                    rdata[CODE_W-1:0]   = cfg[idx].code;
                end
                default:   rdata = '0;
            endcase
        end
    end

    // R1: reset leaves every window disabled
    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (en_vec == '0))
        else $error("window enabled after reset");

    // R11: writes to the unused field code leave all windows untouched
    assert_field3_inert_R11: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel[1:0] == 2'd3) |=> $stable(cfg))
        else $error("field 3 write changed a window");

endmodule

// File: rtl/xlat_win_match.sv
module xlat_win_match
    import xlat_pkg::*;
(
    input  win_cfg_t          cfg,
    input  logic [ADDR_W-1:0] addr,
    output win_res_t          res
);

    logic [ADDR_W-1:0] offset;
    logic [ADDR_W:0]   span;

    assign offset    = addr - pfn_to_addr(cfg.lbase);
    assign span      = win_span(cfg.code);
    assign res.hit   = cfg.en && ({1'b0, offset} < span);
    assign res.xaddr = pfn_to_addr(cfg.tbase) + offset;

endmodule

// File: rtl/xlat_pick.sv
module xlat_pick
    import xlat_pkg::*;
#(
    parameter int unsigned NUM_WIN = 4,
    localparam int unsigned IDX_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic [NUM_WIN-1:0]             hit_vec,
    input  logic [NUM_WIN-1:0][ADDR_W-1:0] xaddrs,
    output logic                           any_hit,
    output logic [IDX_W-1:0]               win_idx,
    output logic [ADDR_W-1:0]              win_xaddr
);

    logic [NUM_WIN-1:0] grant;

    // isolate the lowest set bit: lowest index has priority
    assign grant   = hit_vec & (~hit_vec + NUM_WIN'(1));
    assign any_hit = |hit_vec;

    always_comb begin
        win_idx   = '0;
        win_xaddr = '0;
        for (int w = 0; w < NUM_WIN; w++) begin
            if (grant[w]) begin
                win_idx   = IDX_W'(w);
                win_xaddr = xaddrs[w];
            end
        end
    end

    always_comb begin
        assert_single_grant_R8: assert ($onehot0(grant) && ((grant & ~hit_vec) == '0))
            else $error("priority grant not a single hit");
    end

endmodule

// File: rtl/xlat_outbound_unit.sv
module xlat_outbound_unit
    import xlat_pkg::*;
#(
    parameter int unsigned      NUM_WIN      = 4,
    parameter logic [31:0]      CFG_ADDR_LOC = 32'hE7FF_FFF0,
    parameter logic [31:0]      CFG_DATA_LOC = 32'hE7FF_FFF4,
    localparam int unsigned     IDX_W        = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
    localparam int unsigned     SEL_W        = IDX_W + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr_en,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              req_valid,
    input  logic [31:0]       req_addr,
    output logic              xl_valid,
    output logic              xl_fwd,
    output logic [31:0]       xl_addr,
    output logic [IDX_W-1:0]  xl_win
);

    win_cfg_t [NUM_WIN-1:0]             cfg;
    logic [NUM_WIN-1:0]                 hit_vec;
    logic [NUM_WIN-1:0][ADDR_W-1:0]     xaddrs;
    logic                               any_hit;
    logic [IDX_W-1:0]                   pick_idx;
    logic [ADDR_W-1:0]                  pick_addr;
    logic                               carve;
    logic                               fwd_n;

    xlat_regs #(.NUM_WIN(NUM_WIN)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr_en (cfg_wr_en),
        .sel   (cfg_sel),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .cfg   (cfg)
    );

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_match
        win_res_t res;
        xlat_win_match u_match (
            .cfg  (cfg[w]),
            .addr (req_addr),
            .res  (res)
        );
        assign hit_vec[w] = res.hit;
        assign xaddrs[w]  = res.xaddr;
    end

    xlat_pick #(.NUM_WIN(NUM_WIN)) u_pick (
        .hit_vec   (hit_vec),
        .xaddrs    (xaddrs),
        .any_hit   (any_hit),
        .win_idx   (pick_idx),
        .win_xaddr (pick_addr)
    );

    assign carve = (req_addr[ADDR_W-1:2] == CFG_ADDR_LOC[ADDR_W-1:2]) ||
                   (req_addr[ADDR_W-1:2] == CFG_DATA_LOC[ADDR_W-1:2]);
    assign fwd_n = req_valid && any_hit && !carve;

    always_ff @(posedge clk) begin
        if (rst) begin
            xl_valid <= 1'b0;
            xl_fwd   <= 1'b0;
            xl_addr  <= '0;
            xl_win   <= '0;
        end else begin
            xl_valid <= req_valid;
            xl_fwd   <= fwd_n;
            xl_addr  <= fwd_n ? pick_addr : '0;
            xl_win   <= fwd_n ? pick_idx  : '0;
        end
    end

    // R7: configuration-access words are never forwarded
    assert_carve_out_R7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && (req_addr[31:2] == CFG_ADDR_LOC[31:2] ||
                       req_addr[31:2] == CFG_DATA_LOC[31:2])) |=> !xl_fwd)
        else $error("config-access word forwarded");

    // R9: a non-forwarded result carries a zero address and index
    assert_miss_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (xl_valid && !xl_fwd) |-> (xl_addr == '0 && xl_win == '0))
        else $error("miss carries nonzero address");

    // R10: result valid tracks the request one clock later
    assert_valid_follows_R10: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> xl_valid)
        else $error("request produced no result");

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!xl_valid && !xl_fwd))
        else $error("result without request");

endmodule

// File: tb/sim_xlat_outbound_unit.sv
module sim_xlat_outbound_unit;

    localparam int NW = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr_en = 1'b0;
    logic [3:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        xl_valid;
    logic        xl_fwd;
    logic [31:0] xl_addr;
    logic [1:0]  xl_win;

    int n_chk  = 0;
    int n_fail = 0;

    logic [19:0] m_lb   [NW];
    logic [19:0] m_tb   [NW];
    logic        m_en   [NW];
    logic [5:0]  m_code [NW];

    xlat_outbound_unit #(.NUM_WIN(NW)) u0 (
        .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
        .req_addr(req_addr), .xl_valid(xl_valid), .xl_fwd(xl_fwd),
        .xl_addr(xl_addr), .xl_win(xl_win)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic longint span_of(input logic [5:0] code);
        int e;
        e = int'(code);
        if (e < 11) e = 11;
        if (e > 31) e = 31;
        return longint'(1) << (e + 1);
    endfunction

    function automatic void model(input logic [31:0] a, output logic f,
                                  output logic [31:0] x, output logic [1:0] w);
        logic found;
        logic [31:0] off;
        found = 1'b0;
        f = 1'b0; x = '0; w = '0;
        for (int k = 0; k < NW; k++) begin
            off = a - {m_lb[k], 12'h000};
            if (!found && m_en[k] && (longint'(off) < span_of(m_code[k]))) begin
                found = 1'b1;
                f = 1'b1;
                x = {m_tb[k], 12'h000} + off;
                w = 2'(k);
            end
        end
        if (a[31:2] == 30'(32'hE7FF_FFF0 >> 2) || a[31:2] == 30'(32'hE7FF_FFF4 >> 2)) begin
            f = 1'b0; x = '0; w = '0;
        end
    endfunction

    task automatic wr(input int idx, input int fld, input logic [31:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1;
        cfg_sel   = {2'(idx), 2'(fld)};
        cfg_wdata = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        case (fld)
            0: m_lb[idx] = d[19:0];
            1: m_tb[idx] = d[19:0];
            2: begin m_en[idx] = d[31]; m_code[idx] = d[5:0]; end
            default: ;
        endcase
    endtask

    task automatic rd(input int idx, input int fld, input logic [31:0] exp, input string req);
        @(negedge clk);
        cfg_sel = {2'(idx), 2'(fld)};
        #1;
        chk(req, cfg_rdata, exp);
    endtask

    task automatic do_req(input logic [31:0] a, input string req);
        logic f; logic [31:0] x; logic [1:0] w;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        @(negedge clk);
        req_valid = 1'b0;
        model(a, f, x, w);
        chk({req, " valid"}, 32'(xl_valid), 32'd1);
        chk({req, " fwd"},   32'(xl_fwd),   32'(f));
        chk({req, " addr"},  xl_addr,       x);
        chk({req, " win"},   32'(xl_win),   32'(w));
    endtask

    task automatic sweep(input int k, input string req);
        logic [31:0] b;
        logic [31:0] s;
        b = {m_lb[k], 12'h000};
        s = 32'(span_of(m_code[k]));
        do_req(b - 1, req);
        do_req(b, req);
        do_req(b + 4, req);
        do_req(b + (s >> 1), req);
        do_req(b + s - 4, req);
        do_req(b + s - 1, req);
        do_req(b + s, req);
    endtask

    initial begin
        #(20 * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int k = 0; k < NW; k++) begin
            m_lb[k] = '0; m_tb[k] = '0; m_en[k] = 1'b0; m_code[k] = '0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 xl_valid after reset", 32'(xl_valid), 0);
        chk("R1 xl_addr after reset", xl_addr, 0);
        for (int k = 0; k < NW; k++)
            for (int f = 0; f < 4; f++)
                rd(k, f, 32'h0, "R1 register zero");
        do_req(32'h8000_0000, "R1 no window");

        // R2/R3 programming and readback
        wr(0, 0, 32'h0008_0000);
        wr(0, 1, 32'h000C_0000);
        wr(0, 2, 32'h8004_4012);
        rd(0, 0, 32'h0008_0000, "R2 local base");
        rd(0, 1, 32'h000C_0000, "R2 translated base");
        rd(0, 2, 32'h8000_0012, "R3 attribute");
        wr(0, 0, 32'hFFF8_0000);
        rd(0, 0, 32'h0008_0000, "R2 upper bits dropped");

        // R4 translation, R5 edges
        do_req(32'h8000_0000, "R4 base");
        chk("R4 literal", xl_addr, 32'hC000_0000);
        do_req(32'h8007_FFFF, "R5 last byte");
        chk("R5 last byte literal", xl_addr, 32'hC007_FFFF);
        do_req(32'h8008_0000, "R5 one past");
        chk("R5 one past literal", 32'(xl_fwd), 0);
        sweep(0, "R5 sweep w0");

        // R7 carve-out inside a 128 MB window
        wr(1, 0, 32'h000E_0000);
        wr(1, 1, 32'h000E_0000);
        wr(1, 2, 32'h8000_001A);
        do_req(32'hE7FF_FFF0, "R7 config addr word");
        chk("R7 literal", 32'(xl_fwd), 0);
        do_req(32'hE7FF_FFF4, "R7 config data word");
        do_req(32'hE7FF_FFF7, "R7 data word byte");
        do_req(32'hE7FF_FFEC, "R7 word below");
        chk("R7 below literal", 32'(xl_fwd), 1);
        do_req(32'hE7FF_FFF8, "R7 word above");
        sweep(1, "R4 sweep w1");

        // R6/R8 overlapping 4 KB window
        wr(2, 0, 32'h000E_0000);
        wr(2, 1, 32'h0001_2345);
        wr(2, 2, 32'h8000_0002);
        do_req(32'hE000_0010, "R8 lower index wins");
        chk("R8 literal", 32'(xl_win), 1);
        wr(1, 2, 32'h0000_001A);
        do_req(32'hE000_0010, "R6 small code 4KB");
        chk("R6 literal", xl_addr, 32'h1234_5010);
        do_req(32'hE000_1000, "R6 4KB edge");
        sweep(2, "R6 sweep w2");
        wr(1, 2, 32'h8000_001A);
        do_req(32'hE000_0FFF, "R8 re-enabled w1");
        do_req(32'h0000_1000, "R9 miss");

        // R6 whole-space window
        wr(3, 0, 32'h0001_0000);
        wr(3, 1, 32'h0002_0000);
        wr(3, 2, 32'h8000_003F);
        do_req(32'h0000_1000, "R6 4GB window");
        chk("R6 4GB literal", xl_addr, 32'h1000_1000);
        do_req(32'hE7FF_FFF0, "R7 carve under 4GB");
        do_req(32'h8000_0000, "R8 w0 over w3");
        for (int k = 0; k < 16; k++)
            do_req((32'(k) << 28) | 32'h000A_BC0, "R4 nibble sweep");

        // R9 disable
        wr(0, 2, 32'h0000_0012);
        do_req(32'h8000_0000, "R9 w0 disabled");
        wr(3, 2, 32'h0000_003F);
        do_req(32'h8000_0000, "R9 all miss");
        chk("R9 miss literal", xl_addr, 0);

        // R11 field code 3
        wr(0, 3, 32'hFFFF_FFFF);
        rd(0, 3, 32'h0, "R11 field3 reads zero");
        rd(0, 0, 32'h0008_0000, "R11 base unchanged");
        rd(0, 2, 32'h0000_0012, "R11 attr unchanged");

        // R10 idle cycle
        @(negedge clk);
        req_valid = 1'b0;
        req_addr  = 32'hE000_0010;
        @(negedge clk);
        chk("R10 idle valid", 32'(xl_valid), 0);
        chk("R10 idle fwd", 32'(xl_fwd), 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule